// File: doc/BRIEF.md
# Segment Display Interrupt Vector Unit

This block gathers the four interrupt causes of a segment display controller into one interrupt request and one vector register. The causes are a frame boundary, the start of a blink-on phase, the start of a blink-off phase, and a missing charge-pump capacitor. Each cause has a flag and an enable. The unit reports the most urgent cause that is both pending and enabled as an even number, so software can use it directly as a jump-table offset.

The blink flags come from edges of the blink clock, and which edge sets which flag depends on the blink mode. The frame and blink flags clear themselves whenever software writes display or blink memory. Reading the vector register acknowledges only the cause it reports. Writing the vector register acknowledges every cause. Single flags can also be cleared through the flag register.

Software reaches the unit through a small register bus with three registers:
- address 0 is the enable register;
- address 1 is the flag register;
- address 2 is the vector register.

Reads return combinationally in the cycle of the read strobe, and any side effects take place at the clock edge that ends that cycle.

Top module: `segirq_vector_unit`

## Requirements
- R1: After reset, the enable register, the flag register, the vector register and `irq` all read 0.
- R2: The vector register (address 2) returns the code of the highest-priority source that is both pending and enabled. Priority from highest to lowest is no-capacitor, blink-on, blink-off, frame. The codes are 2, 4, 6 and 8 in that order, and 0 means no such source. A source whose enable bit is 0 never changes the vector.
- R3: `irq` is high exactly one clock cycle after the AND of flags and enables is nonzero.
- R4: A read of the vector register clears only the flag it reports, and any other enabled pending flags keep `irq` high.
- R5: A write of any value to the vector register clears all flags.
- R6: In the flag register (address 1), bit 0 is frame, bit 1 is blink-off, bit 2 is blink-on and bit 3 is no-capacitor. Writing a 1 to a bit clears that flag, and writing a 0 leaves it unchanged.
- R7: In blink modes 01 and 10, a rising blink-clock edge sets blink-on and a falling edge sets blink-off.
- R8: In blink mode 11, the display source starts at normal memory when the mode is entered and toggles on every rising blink-clock edge. A toggle to blink memory sets blink-on, a toggle back to normal memory sets blink-off, and falling edges set nothing.
- R9: In blink mode 00, no blink-clock edge sets either blink flag.
- R10: A `mem_wr` pulse clears the frame, blink-on and blink-off flags but leaves the no-capacitor flag unchanged.
- R11: The no-capacitor flag sets in any cycle where `pump_en` and `cap_missing` are both high, and never while `pump_en` is low.
- R12: When a set event and a clearing action hit the same flag in the same cycle, the flag ends up set.
- R13: A `frame_tick` pulse sets the frame flag. The enable register (address 0) uses the same bit positions as the flag register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| frame_tick | input | 1 | One-cycle strobe at each frame boundary |
| blink_clk | input | 1 | Blink clock level, synchronous to clk |
| blink_mode | input | 2 | Blink mode: 00 off, 01/10 blink, 11 memory swap |
| pump_en | input | 1 | Charge pump enabled |
| cap_missing | input | 1 | No capacitor detected on the capacitor pin |
| mem_wr | input | 1 | Strobe: a display or blink memory register was written |
| bus_rd | input | 1 | Register read strobe |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address (0 enable, 1 flags, 2 vector) |
| bus_wdata | input | 4 | Register write data |
| bus_rdata | output | 16 | Register read data |
| irq | output | 1 | Registered interrupt request |

## Verification
The bench fills all four flags and then drains them through successive vector reads. An encoder with the wrong priority order, or a read that cleared more than one flag, would return the codes out of sequence or too few of them. It raises a frame tick in the same cycle as a memory write, and again in the same cycle as a vector write, which exposes a design that lets the clear win. It runs memory-swap mode through two rising edges and a falling edge to catch a swap toggle that follows the level instead of the edge. It changes the enables while flags are pending, so a vector that ignores disabled sources becomes visible, and it checks that a memory write leaves the capacitor flag in place.

// File: rtl/segirq_pkg.sv
package segirq_pkg;

  // Number of interrupt sources and their bit positions (higher index = higher priority)
  localparam int NSRC       = 4;
  localparam int IDX_FRAME  = 0;
  localparam int IDX_BOFF   = 1;
  localparam int IDX_BON    = 2;
  localparam int IDX_NOCAP  = 3;

  typedef logic [NSRC-1:0] src_vec_t;

  // Register addresses on the control bus
  typedef enum logic [1:0] {
    REG_ENABLE = 2'd0,
    REG_FLAGS  = 2'd1,
    REG_VECTOR = 2'd2,
    REG_NONE   = 2'd3
  } reg_addr_e;

  // Blink operating modes
  typedef enum logic [1:0] {
    BLK_OFF   = 2'b00,
    BLK_PH_A  = 2'b01,
    BLK_PH_B  = 2'b10,
    BLK_SWAP  = 2'b11
  } blink_mode_e;

  // Flags that a display/blink memory write auto-clears
  localparam src_vec_t MEMWR_CLR_MASK = src_vec_t'((1 << IDX_FRAME) | (1 << IDX_BOFF) | (1 << IDX_BON));

endpackage

// File: rtl/segirq_rst_sync.sv
module segirq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_n;

  always_comb begin
    chain_n = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_n;
    end
  end

  assign rst_s = chain_q[STAGES-1];

endmodule

// File: rtl/segirq_blink_edge.sv
module segirq_blink_edge
  import segirq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       blink_clk,
  input  logic [1:0] blink_mode,
  output logic       on_evt,
  output logic       off_evt
);

  logic blink_q;
  logic sel_q;     // 1: blink memory currently selected in swap mode
  logic sel_n;
  logic sel_en;
  logic rise;
  logic fall;

  assign rise = blink_clk & ~blink_q;
  assign fall = ~blink_clk & blink_q;

  // Event generation per mode
  always_comb begin
    on_evt  = 1'b0;
    off_evt = 1'b0;
    unique case (blink_mode_e'(blink_mode))
      BLK_OFF: begin
        on_evt  = 1'b0;
        off_evt = 1'b0;
      end
      BLK_SWAP: begin
        on_evt  = rise & ~sel_q;
        off_evt = rise & sel_q;
      end
      default: begin
        on_evt  = rise;
        off_evt = fall;
      end
    endcase
  end

  // Display-source selection for swap mode
  always_comb begin
    if (blink_mode_e'(blink_mode) != BLK_SWAP) begin
      sel_n = 1'b0;
    end else if (rise) begin
      sel_n = ~sel_q;
    end else begin
      sel_n = sel_q;
    end
    sel_en = (sel_n != sel_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blink_q <= 1'b0;
    end else begin
      blink_q <= blink_clk;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= 1'b0;
    end else if (sel_en) begin
      sel_q <= sel_n;
    end
  end

endmodule

// File: rtl/segirq_flag_bank.sv
module segirq_flag_bank
  import segirq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  src_vec_t set_evt,
  input  src_vec_t clr_mask,
  output src_vec_t flags
);

  src_vec_t flags_q;
  src_vec_t flags_n;
  logic     upd_en;

  // Set has priority over clear so no hardware event is lost
  always_comb begin
    for (int i = 0; i < NSRC; i++) begin
      flags_n[i] = set_evt[i] | (flags_q[i] & ~clr_mask[i]);
    end
    upd_en = |(flags_n ^ flags_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
    end else if (upd_en) begin
      flags_q <= flags_n;
    end
  end

  assign flags = flags_q;

endmodule

// File: rtl/segirq_prio.sv
module segirq_prio
  import segirq_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int VEC_STEP = 2
) (
  input  src_vec_t          pend,
  output src_vec_t          hi_onehot,
  output logic [DATA_W-1:0] vec_code
);

  logic [NSRC:0] above;   // above[i]: some source with index >= i is pending

  assign above[NSRC] = 1'b0;

  genvar g;
  generate
    for (g = NSRC - 1; g >= 0; g--) begin : g_lvl
      assign above[g]     = above[g+1] | pend[g];
      assign hi_onehot[g] = pend[g] & ~above[g+1];
    end
  endgenerate

  // Code for index i: (NSRC - i) * VEC_STEP, 0 when nothing pending
  always_comb begin
    vec_code = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (hi_onehot[i]) begin
        vec_code = DATA_W'((NSRC - i) * VEC_STEP);
      end
    end
  end

endmodule

// File: rtl/segirq_vector_unit.sv
module segirq_vector_unit
  import segirq_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int VEC_STEP    = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_tick,
  input  logic              blink_clk,
  input  logic [1:0]        blink_mode,
  input  logic              pump_en,
  input  logic              cap_missing,
  input  logic              mem_wr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [1:0]        bus_addr,
  input  logic [NSRC-1:0]   bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);

  localparam int PAD_W = DATA_W - NSRC;

  logic              rst_s;
  logic              on_evt;
  logic              off_evt;
  src_vec_t          set_evt;
  src_vec_t          clr_mask;
  src_vec_t          flags_q;
  src_vec_t          en_q;
  src_vec_t          pend;
  src_vec_t          hi_onehot;
  logic [DATA_W-1:0] vec_code;
  logic              en_wr;
  logic              flag_wr;
  logic              vec_wr;
  logic              vec_rd;
  logic              irq_n;
  logic              irq_q;

  segirq_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk   (clk),
    .rst_n (rst_n),
    .rst_s (rst_s)
  );

  segirq_blink_edge u_blink (
    .clk        (clk),
    .rst_n      (rst_s),
    .blink_clk  (blink_clk),
    .blink_mode (blink_mode),
    .on_evt     (on_evt),
    .off_evt    (off_evt)
  );

  // Bus decode
  always_comb begin
    en_wr   = bus_wr && (reg_addr_e'(bus_addr) == REG_ENABLE);
    flag_wr = bus_wr && (reg_addr_e'(bus_addr) == REG_FLAGS);
    vec_wr  = bus_wr && (reg_addr_e'(bus_addr) == REG_VECTOR);
    vec_rd  = bus_rd && (reg_addr_e'(bus_addr) == REG_VECTOR);
  end

  // Hardware set events
  always_comb begin
    set_evt            = '0;
    set_evt[IDX_FRAME] = frame_tick;
    set_evt[IDX_BOFF]  = off_evt;
    set_evt[IDX_BON]   = on_evt;
    set_evt[IDX_NOCAP] = pump_en & cap_missing;
  end

  // All clearing actions merged
  always_comb begin
    clr_mask = '0;
    if (mem_wr)  clr_mask = clr_mask | MEMWR_CLR_MASK;
    if (vec_rd)  clr_mask = clr_mask | hi_onehot;
    if (vec_wr)  clr_mask = '1;
    if (flag_wr) clr_mask = clr_mask | bus_wdata;
  end

  segirq_flag_bank u_flags (
    .clk      (clk),
    .rst_n    (rst_s),
    .set_evt  (set_evt),
    .clr_mask (clr_mask),
    .flags    (flags_q)
  );

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      en_q <= '0;
    end else if (en_wr) begin
      en_q <= bus_wdata;
    end
  end

  assign pend = flags_q & en_q;

  segirq_prio #(.DATA_W(DATA_W), .VEC_STEP(VEC_STEP)) u_prio (
    .pend      (pend),
    .hi_onehot (hi_onehot),
    .vec_code  (vec_code)
  );

  // Read data
  always_comb begin
    unique case (reg_addr_e'(bus_addr))
      REG_ENABLE: bus_rdata = {{PAD_W{1'b0}}, en_q};
      REG_FLAGS:  bus_rdata = {{PAD_W{1'b0}}, flags_q};
      REG_VECTOR: bus_rdata = vec_code;
      default:    bus_rdata = '0;
    endcase
  end

  // Registered interrupt request
  assign irq_n = |pend;

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      irq_q <= 1'b0;
    end else if (irq_n != irq_q) begin
      irq_q <= irq_n;
    end
  end

  assign irq = irq_q;

endmodule

// File: rtl/segirq_vector_unit_chk.sv
module segirq_vector_unit_chk
  import segirq_pkg::*;
(
  input logic       clk,
  input logic       rst_s,
  input logic       irq,
  input src_vec_t   flags,
  input src_vec_t   en,
  input src_vec_t   set_evt,
  input src_vec_t   hi_onehot,
  input logic       mem_wr,
  input logic       vec_rd,
  input logic       vec_wr,
  input logic       bus_wr,
  input logic [1:0] blink_mode
);

  // R3
  irq_lag_chk: assert property (@(posedge clk) disable iff (!rst_s)
    irq == $past(|(flags & en)));

  // R5
  vec_wr_clear_chk: assert property (@(posedge clk) disable iff (!rst_s)
    vec_wr |=> (flags == $past(set_evt)));

  // R12
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (|set_evt) |=> ((flags & $past(set_evt)) == $past(set_evt)));

  // R10
  memwr_clear_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (mem_wr && set_evt[IDX_BON:IDX_FRAME] == '0) |=> (flags[IDX_BON:IDX_FRAME] == '0));

  // R9
  blink_off_mode_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (blink_mode == 2'b00) |-> (set_evt[IDX_BON:IDX_BOFF] == 2'b00));

  // R4
  read_one_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (vec_rd && !bus_wr && !mem_wr && set_evt == '0 && $countones(flags & en) >= 2)
      |=> ($countones(flags & en) + 1 == $past($countones(flags & en))));

  // R2
  onehot_chk: assert property (@(posedge clk) disable iff (!rst_s)
    $onehot0(hi_onehot) && ((hi_onehot & ~(flags & en)) == '0));

endmodule

bind segirq_vector_unit segirq_vector_unit_chk u_chk (
  .clk        (clk),
  .rst_s      (rst_s),
  .irq        (irq),
  .flags      (flags_q),
  .en         (en_q),
  .set_evt    (set_evt),
  .hi_onehot  (hi_onehot),
  .mem_wr     (mem_wr),
  .vec_rd     (vec_rd),
  .vec_wr     (vec_wr),
  .bus_wr     (bus_wr),
  .blink_mode (blink_mode)
);

// File: tb/sim_segirq_vector_unit.sv
module sim_segirq_vector_unit;

  localparam logic [1:0] A_EN  = 2'd0;
  localparam logic [1:0] A_FLG = 2'd1;
  localparam logic [1:0] A_VEC = 2'd2;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        frame_tick;
  logic        blink_clk;
  logic [1:0]  blink_mode;
  logic        pump_en;
  logic        cap_missing;
  logic        mem_wr;
  logic        bus_rd;
  logic        bus_wr;
  logic [1:0]  bus_addr;
  logic [3:0]  bus_wdata;
  logic [15:0] bus_rdata;
  logic        irq;

  int checks   = 0;
  int failures = 0;
  bit done     = 0;

  typedef struct {
    logic [15:0] exp;
    string       tag;
  } exp_t;

  exp_t sb_q[$];

  always #10 clk = ~clk;   // 50 MHz

  segirq_vector_unit u0 (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_tick  (frame_tick),
    .blink_clk   (blink_clk),
    .blink_mode  (blink_mode),
    .pump_en     (pump_en),
    .cap_missing (cap_missing),
    .mem_wr      (mem_wr),
    .bus_rd      (bus_rd),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .irq         (irq)
  );

  // Monitor: compares read data against the scoreboard in mid-cycle
  always @(negedge clk) begin
    if (bus_rd && rst_n) begin
      exp_t e;
      checks++;
      if (sb_q.size() == 0) begin
        failures++;
        $display("FAIL scoreboard: read with no expected item, actual=%0h", bus_rdata);
      end else begin
        e = sb_q.pop_front();
        if (bus_rdata !== e.exp) begin
          failures++;
          $display("FAIL %s: actual=%0h expected=%0h", e.tag, bus_rdata, e.exp);
        end
      end
    end
  end

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic bus_read(input logic [1:0] a, input logic [15:0] exp, input string tag);
    exp_t e;
    e.exp = exp;
    e.tag = tag;
    sb_q.push_back(e);
    bus_rd   = 1'b1;
    bus_addr = a;
    step();
    bus_rd   = 1'b0;
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [3:0] d);
    bus_wr    = 1'b1;
    bus_addr  = a;
    bus_wdata = d;
    step();
    bus_wr    = 1'b0;
  endtask

  task automatic chk_irq(input logic exp, input string tag);
    @(negedge clk);
    checks++;
    if (irq !== exp) begin
      failures++;
      $display("FAIL %s: irq actual=%0b expected=%0b", tag, irq, exp);
    end
    step();
  endtask

  task automatic pulse_frame();
    frame_tick = 1'b1;
    step();
    frame_tick = 1'b0;
  endtask

  task automatic pulse_pump();
    pump_en     = 1'b1;
    cap_missing = 1'b1;
    step();
    pump_en     = 1'b0;
    cap_missing = 1'b0;
  endtask

  task automatic set_blink(input logic v);
    blink_clk = v;
    step();
  endtask

  initial begin
    rst_n = 1'b0; frame_tick = 0; blink_clk = 0; blink_mode = 2'b00;
    pump_en = 0; cap_missing = 0; mem_wr = 0;
    bus_rd = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0;
    idle(3);
    rst_n = 1'b1;
    idle(4);

    // R1 reset state
    bus_read(A_EN,  16'h0, "R1 enable");
    bus_read(A_FLG, 16'h0, "R1 flags");
    bus_read(A_VEC, 16'h0, "R1 vector");
    chk_irq(1'b0, "R1 irq");

    // R13 frame flag, R2 disabled source leaves vector at 0
    pulse_frame();
    bus_read(A_FLG, 16'h1, "R13 frame flag");
    bus_read(A_VEC, 16'h0, "R2 disabled vector");
    bus_read(A_FLG, 16'h1, "R2 disabled not cleared");
    chk_irq(1'b0, "R2 disabled irq");

    bus_write(A_EN, 4'hF);
    bus_read(A_EN, 16'hF, "R13 enable readback");
    bus_write(A_VEC, 4'h0);
    bus_read(A_FLG, 16'h0, "R5 vector write clears");
    idle(2);
    chk_irq(1'b0, "R3 idle");

    // R3 latency
    pulse_frame();
    chk_irq(1'b0, "R3 before register");
    chk_irq(1'b1, "R3 after register");
    bus_read(A_VEC, 16'h8, "R2 frame code");
    bus_read(A_FLG, 16'h0, "R4 frame cleared");

    // R11 capacitor detection
    cap_missing = 1'b1;
    idle(2);
    cap_missing = 1'b0;
    bus_read(A_FLG, 16'h0, "R11 pump off");
    pulse_pump();
    bus_read(A_FLG, 16'h8, "R11 pump on");

    // R7 mode 01
    blink_mode = 2'b01;
    step();
    set_blink(1'b1);
    bus_read(A_FLG, 16'hC, "R7 rise sets on");
    set_blink(1'b0);
    bus_read(A_FLG, 16'hE, "R7 fall sets off");
    pulse_frame();

    // R4 drain in priority order
    bus_read(A_VEC, 16'h2, "R4 nocap first");
    bus_read(A_VEC, 16'h4, "R4 blink-on second");
    bus_read(A_FLG, 16'h3, "R4 only top cleared");
    chk_irq(1'b1, "R4 irq stays");
    bus_read(A_VEC, 16'h6, "R4 blink-off third");
    bus_read(A_VEC, 16'h8, "R4 frame fourth");
    bus_read(A_VEC, 16'h0, "R4 empty");
    idle(2);
    chk_irq(1'b0, "R3 irq drops");

    // R6 write-one-to-clear
    pulse_pump();
    set_blink(1'b1);
    set_blink(1'b0);
    bus_read(A_FLG, 16'hE, "R6 setup");
    bus_write(A_FLG, 4'h4);
    bus_read(A_FLG, 16'hA, "R6 clear blink-on only");
    bus_write(A_FLG, 4'hF);
    bus_read(A_FLG, 16'h0, "R6 clear all");

    // R10 memory write
    pulse_pump();
    pulse_frame();
    set_blink(1'b1);
    set_blink(1'b0);
    mem_wr = 1'b1;
    step();
    mem_wr = 1'b0;
    bus_read(A_FLG, 16'h8, "R10 nocap survives");
    bus_write(A_VEC, 4'h0);

    // R9 mode 00
    blink_mode = 2'b00;
    step();
    set_blink(1'b1);
    set_blink(1'b0);
    bus_read(A_FLG, 16'h0, "R9 no blink flags");

    // R8 swap mode
    blink_mode = 2'b11;
    step();
    set_blink(1'b1);
    bus_read(A_FLG, 16'h4, "R8 first rise to blink memory");
    set_blink(1'b0);
    bus_read(A_FLG, 16'h4, "R8 fall no event");
    set_blink(1'b1);
    bus_read(A_FLG, 16'h6, "R8 second rise to normal memory");
    bus_write(A_VEC, 4'h0);
    set_blink(1'b0);

    // R7 mode 10
    blink_mode = 2'b10;
    step();
    set_blink(1'b1);
    bus_read(A_FLG, 16'h4, "R7 mode10 rise");
    set_blink(1'b0);
    bus_read(A_FLG, 16'h6, "R7 mode10 fall");
    bus_write(A_VEC, 4'h0);

    // R12 set beats clear
    frame_tick = 1'b1;
    mem_wr     = 1'b1;
    step();
    frame_tick = 1'b0;
    mem_wr     = 1'b0;
    bus_read(A_FLG, 16'h1, "R12 frame vs mem write");
    frame_tick = 1'b1;
    bus_write(A_VEC, 4'h0);
    frame_tick = 1'b0;
    bus_read(A_FLG, 16'h1, "R12 frame vs vector write");

    // R2 enable masking
    pulse_pump();
    set_blink(1'b1);
    set_blink(1'b0);
    bus_write(A_EN, 4'h1);
    bus_read(A_VEC, 16'h8, "R2 only frame enabled");
    bus_read(A_FLG, 16'hE, "R4 read cleared frame only");
    bus_write(A_EN, 4'h6);
    bus_read(A_VEC, 16'h4, "R2 blink-on above blink-off");
    bus_read(A_FLG, 16'hA, "R4 blink-on cleared");
    bus_write(A_EN, 4'h0);
    bus_read(A_VEC, 16'h0, "R2 all disabled");
    bus_read(A_FLG, 16'hA, "R2 disabled untouched");

    idle(3);
    if (sb_q.size() != 0) begin
      failures++;
      $display("FAIL scoreboard: %0d items left, expected 0", sb_q.size());
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run incomplete, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule